// File: doc/BRIEF.md
# Parallel Bus Master Transfer Engine

This block drives a 16-bit parallel bus toward an external slave device. The host side has three parts: a transmit FIFO write port, a receive FIFO read port and a control write port. The control write carries a read-start bit, a word count and a clock divider value. The bus side drives write, read and clock/chip-select strobes. It also drives a request line that is active during every bus cycle, a data bus with its output enable, and it samples incoming read data.

The transmit FIFO drains to the bus on its own, one write cycle per word, as long as words remain. A read burst starts when the host sets the read-start bit. The burst waits until the transmit FIFO is empty, then fetches count+1 words into the receive FIFO. While the burst runs, writes are held back. The busy flag drops on its own once the last word is stored. Every bus cycle is timed by a transfer tick that is made by integer division of the system clock.

Top module: `pbus_master`

## Requirements
- R1: Each word pushed into the transmit FIFO produces exactly one write cycle. These cycles run in push order, with no host action, and each starts one idle clock after the previous one ends.
- R2: A control write with `ctl_read`=1 sets `read_busy` on the next clock. `read_busy` returns to 0 on its own once the last word of the burst has been stored.
- R3: A read burst issues `ctl_count`+1 read cycles. It stores the sampled `bus_din` words in the receive FIFO, in bus order.
- R4: A read requested while the transmit FIFO holds words begins only after every one of those words has been written.
- R5: No write cycle starts while a read burst is running. Words pushed during the burst are written after its last read.
- R6: Each bus cycle has three phases. First a setup phase of D clocks, with the write or read strobe high and `bus_cs` low. Then a strobe phase of D clocks, with `bus_cs` high. Then a hold clock, with the strobes low and the write data still driven. D equals the divider value, and a divider of 0 acts as 1.
- R7: When the receive FIFO (4 entries) is full, the next read cycle stalls until the host pops a word, and the burst then completes.
- R8: The count is latched when the burst is requested. A control write while `read_busy`=1 changes neither the burst length nor its state.
- R9: `bus_oe` is high only during write cycles. It is never high together with `bus_rd`.
- R10: `bus_rreq` is high during the setup and strobe phases of every read and write cycle.
- R11: Under reset all strobes, `bus_oe`, `bus_rreq` and `read_busy` are 0, and both FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Push a word into the transmit FIFO |
| tx_wdata | input | 16 | Word to transmit |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_pop | input | 1 | Pop the head of the receive FIFO |
| rx_rdata | output | 16 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_read | input | 1 | Read-start bit of the control write |
| ctl_count | input | 8 | Burst length minus one |
| ctl_div | input | 8 | Transfer clock divider (0 acts as 1) |
| read_busy | output | 1 | Read bit readback, self-clearing |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_cs | output | 1 | Combined clock/chip-select strobe |
| bus_rreq | output | 1 | Request line, active in every bus cycle |
| bus_oe | output | 1 | Data bus output enable |
| bus_dout | output | 16 | Data driven onto the bus |
| bus_din | input | 16 | Data sampled from the bus |

## Verification
Plain write streams are run at divider values 2 and 0, so that phase length and word order are checked separately from any read logic. A read burst on its own checks the count+1 length and the self-clearing busy flag. A full transmit FIFO followed by a read request, with more pushes during the burst, checks both sides of the arbitration through the order of cycle types seen on the bus. A burst longer than the receive FIFO with no popping shows the stall. A second control write during a running burst shows that the latched count stays in force.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef enum logic {
        CYC_WR,
        CYC_RD
    } cyc_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic cs;
        logic req;
        logic oe;
    } bus_ctl_t;

    // Strobe pattern for a given phase of a given cycle type
    function automatic bus_ctl_t phase_ctl(phase_e ph, cyc_e kind);
        bus_ctl_t c;
        c = '0;
        c.wr  = (kind == CYC_WR) && (ph == PH_SETUP || ph == PH_STROBE);
        c.rd  = (kind == CYC_RD) && (ph == PH_SETUP || ph == PH_STROBE);
        c.cs  = (ph == PH_STROBE);
        c.req = (ph == PH_SETUP || ph == PH_STROBE);
        c.oe  = (kind == CYC_WR) && (ph != PH_IDLE);
        return c;
    endfunction

endpackage

// File: rtl/pbm_fifo.sv
module pbm_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop)
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/pbm_clkdiv.sv
module pbm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (div == '0) ? '0 : div - 1'b1;
    assign tick = !clr && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt == lim)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pbm_seq.sv
module pbm_seq
    import pbm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_full,
    input  logic              ctl_wr,
    input  logic              ctl_read,
    input  logic [CNT_W-1:0]  ctl_count,
    input  logic [DATA_W-1:0] bus_din,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              read_busy,
    output logic              burst,
    output logic              div_clr,
    output bus_ctl_t          bus,
    output logic [DATA_W-1:0] bus_dout
);
    phase_e            phase;
    cyc_e              kind;
    logic [DATA_W-1:0] dout_q;
    logic              read_pend;
    logic              reading;
    logic [CNT_W-1:0]  left;

    logic start_rd, start_wr, rd_done;

    assign start_rd = (phase == PH_IDLE) && read_pend && (reading || tx_empty) && !rx_full;
    assign start_wr = (phase == PH_IDLE) && !reading && !tx_empty;
    assign rd_done  = (phase == PH_STROBE) && tick && (kind == CYC_RD);

    assign tx_pop    = start_wr;
    assign rx_push   = rd_done;
    assign rx_data   = bus_din;
    assign read_busy = read_pend;
    assign burst     = reading;
    assign div_clr   = (phase == PH_IDLE);
    assign bus       = phase_ctl(phase, kind);
    assign bus_dout  = dout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            kind      <= CYC_WR;
            dout_q    <= '0;
            read_pend <= 1'b0;
            reading   <= 1'b0;
            left      <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start_rd) begin
                        kind    <= CYC_RD;
                        reading <= 1'b1;
                        phase   <= PH_SETUP;
                    end else if (start_wr) begin
                        kind   <= CYC_WR;
                        dout_q <= tx_data;
                        phase  <= PH_SETUP;
                    end
                end
                PH_SETUP:  if (tick) phase <= PH_STROBE;
                PH_STROBE: if (tick) phase <= PH_HOLD;
                default:   phase <= PH_IDLE;
            endcase

            if (rd_done) begin
                if (left == '0) begin
                    read_pend <= 1'b0;
                    reading   <= 1'b0;
                end else begin
                    left <= left - 1'b1;
                end
            end

            if (ctl_wr && ctl_read && !read_pend) begin
                read_pend <= 1'b1;
                left      <= ctl_count;
            end
        end
    end
endmodule

// File: rtl/pbus_master.sv
module pbus_master
    import pbm_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 8,
    parameter int DIV_W    = 8,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              rx_empty,
    input  logic              ctl_wr,
    input  logic              ctl_read,
    input  logic [CNT_W-1:0]  ctl_count,
    input  logic [DIV_W-1:0]  ctl_div,
    output logic              read_busy,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic              bus_cs,
    output logic              bus_rreq,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din
);
    logic [DIV_W-1:0]  div_q;
    logic              tick, div_clr;
    logic              tx_pop;
    logic [DATA_W-1:0] tx_head;
    logic              rx_push, rx_full_i;
    logic [DATA_W-1:0] rx_wdata;
    logic              rd_burst;
    bus_ctl_t          bus;

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (ctl_wr)
            div_q <= ctl_div;
    end

    pbm_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(tx_push), .din(tx_wdata),
        .pop(tx_pop), .dout(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    pbm_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .din(rx_wdata),
        .pop(rx_pop), .dout(rx_rdata),
        .empty(rx_empty), .full(rx_full_i)
    );

    pbm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .clr(div_clr), .div(div_q), .tick(tick)
    );

    pbm_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .tick(tick),
        .tx_empty(tx_empty), .tx_data(tx_head),
        .rx_full(rx_full_i),
        .ctl_wr(ctl_wr), .ctl_read(ctl_read), .ctl_count(ctl_count),
        .bus_din(bus_din),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_wdata),
        .read_busy(read_busy), .burst(rd_burst), .div_clr(div_clr),
        .bus(bus), .bus_dout(bus_dout)
    );

    assign bus_wr   = bus.wr;
    assign bus_rd   = bus.rd;
    assign bus_cs   = bus.cs;
    assign bus_rreq = bus.req;
    assign bus_oe   = bus.oe;
endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_cs,
    input logic              bus_rreq,
    input logic              bus_oe,
    input logic [DATA_W-1:0] bus_dout,
    input logic              rx_push,
    input logic              rx_full_i,
    input logic              rd_burst
);
    AST_OE_NOT_WITH_RD: assert property (@(posedge clk) disable iff (rst)
        !(bus_oe && bus_rd)); // R9
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd)); // R6
    AST_CS_INSIDE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bus_cs |-> (bus_wr || bus_rd)); // R6
    AST_REQ_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr || bus_rd) |-> bus_rreq); // R10
    AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_dout)); // R6
    AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full_i); // R7
    AST_NO_WR_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        rd_burst |-> !bus_wr); // R5
endmodule

bind pbus_master pbm_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pbus_master_tb_top.sv
`timescale 1ns/1ps
module pbus_master_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_push = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        tx_full, tx_empty;
    logic        rx_pop = 1'b0;
    logic [15:0] rx_rdata;
    logic        rx_empty;
    logic        ctl_wr = 1'b0;
    logic        ctl_read = 1'b0;
    logic [7:0]  ctl_count = '0;
    logic [7:0]  ctl_div = '0;
    logic        read_busy;
    logic        bus_wr, bus_rd, bus_cs, bus_rreq, bus_oe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;

    int checks = 0;
    int errors = 0;
    logic [15:0] wq[$];
    logic [15:0] rq[$];
    string seq_log = "";
    int exp_div = 1;
    logic [15:0] rd_pat = 16'h1357;

    always #2.5 clk = ~clk;

    pbus_master dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor / slave model
    logic        prev_cs = 1'b0, prev_rd = 1'b0, last_wr = 1'b0;
    int          setup_len = 0, cs_len = 0;
    logic [15:0] last_dout = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_rd && !prev_rd) begin
                bus_din <= rd_pat;
                rq.push_back(rd_pat);
                rd_pat = rd_pat + 16'h0101;
                chk(!bus_oe, "R9", "oe at read strobe", bus_oe, 0);
            end
            if ((bus_wr || bus_rd) && !bus_cs) setup_len++;
            if (bus_cs && !prev_cs) begin
                chk(setup_len == exp_div, "R6", "setup length", setup_len, exp_div);
                chk(bus_rreq, "R10", "request in strobe", bus_rreq, 1);
                setup_len = 0;
                cs_len = 1;
                last_wr = bus_wr;
                if (bus_wr) begin
                    seq_log = {seq_log, "W"};
                    if (wq.size() == 0)
                        chk(0, "R1", "unexpected write", bus_dout, -1);
                    else begin
                        last_dout = wq.pop_front();
                        chk(bus_dout == last_dout, "R1", "write data", bus_dout, last_dout);
                    end
                end else begin
                    seq_log = {seq_log, "R"};
                end
            end else if (bus_cs) begin
                cs_len++;
            end else if (prev_cs) begin
                chk(cs_len == exp_div, "R6", "strobe length", cs_len, exp_div);
                if (last_wr)
                    chk(bus_oe && !bus_wr && bus_dout == last_dout, "R6", "write hold data",
                        bus_dout, last_dout);
            end
            if (bus_oe && bus_rd) chk(0, "R9", "oe with rd", 1, 0);
            prev_cs = bus_cs;
            prev_rd = bus_rd;
        end
    end

    task automatic ctl(input bit rd, input int cnt, input int dv);
        @(posedge clk); #1;
        ctl_wr = 1'b1; ctl_read = rd; ctl_count = 8'(cnt); ctl_div = 8'(dv);
        @(posedge clk); #1;
        ctl_wr = 1'b0; ctl_read = 1'b0;
    endtask

    task automatic push_tx(input logic [15:0] d);
        @(negedge clk);
        while (tx_full) @(negedge clk);
        @(posedge clk); #1;
        tx_push = 1'b1; tx_wdata = d;
        wq.push_back(d);
        @(posedge clk); #1;
        tx_push = 1'b0;
    endtask

    task automatic pop_rx(input string req);
        logic [15:0] e;
        @(negedge clk);
        while (rx_empty) @(negedge clk);
        e = (rq.size() != 0) ? rq.pop_front() : 16'hxxxx;
        chk(rx_rdata == e, req, "read data", rx_rdata, e);
        @(posedge clk); #1;
        rx_pop = 1'b1;
        @(posedge clk); #1;
        rx_pop = 1'b0;
    endtask

    task automatic wait_quiet();
        @(negedge clk);
        while (!(tx_empty && !read_busy)) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    function automatic int count_r(string s);
        int n = 0;
        for (int i = 0; i < s.len(); i++) if (s[i] == "R") n++;
        return n;
    endfunction

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(!bus_wr && !bus_rd && !bus_cs && !bus_oe && !bus_rreq, "R11", "strobes in reset",
            {bus_wr, bus_rd, bus_cs, bus_oe, bus_rreq}, 0);
        chk(!read_busy && rx_empty && tx_empty, "R11", "flags in reset",
            {read_busy, rx_empty, tx_empty}, 3'b011);
        @(posedge clk); #1;
        rst = 1'b0;

        // R1/R6: writes at divider 2
        exp_div = 2; seq_log = "";
        ctl(0, 0, 2);
        push_tx(16'hA001); push_tx(16'hB002); push_tx(16'hC003);
        wait_quiet();
        chk(seq_log == "WWW", "R1", "write count", seq_log.len(), 3);

        // R6: divider 0 acts as 1
        exp_div = 1; seq_log = "";
        ctl(0, 0, 0);
        push_tx(16'h0F0F); push_tx(16'hF0F0);
        wait_quiet();
        chk(seq_log == "WW", "R6", "writes at div 0", seq_log.len(), 2);

        // R2/R3: read burst of COUNT+1
        exp_div = 3; seq_log = "";
        ctl(1, 2, 3);
        @(negedge clk);
        chk(read_busy, "R2", "busy after request", read_busy, 1);
        wait_quiet();
        chk(seq_log == "RRR", "R3", "read count", count_r(seq_log), 3);
        chk(!read_busy, "R2", "busy self-clears", read_busy, 0);
        for (int i = 0; i < 3; i++) pop_rx("R3");
        @(negedge clk);
        chk(rx_empty, "R3", "no extra words", rx_empty, 1);

        // R4/R5: arbitration
        exp_div = 1; seq_log = "";
        ctl(0, 0, 1);
        for (int i = 0; i < 4; i++) push_tx(16'h4400 + 16'(i));
        ctl(1, 3, 1);
        @(negedge clk);
        while (count_r(seq_log) == 0) @(negedge clk);
        push_tx(16'h5501); push_tx(16'h5502);
        wait_quiet();
        chk(seq_log == "WWWWRRRRWW", "R4", "writes before read", seq_log.len(), 10);
        chk(seq_log.substr(4, 7) == "RRRR", "R5", "no write inside burst", count_r(seq_log), 4);
        for (int i = 0; i < 4; i++) pop_rx("R3");

        // R7: receive FIFO full stalls
        seq_log = "";
        ctl(1, 5, 1);
        repeat (200) @(negedge clk);
        chk(count_r(seq_log) == 4, "R7", "reads stop at full", count_r(seq_log), 4);
        chk(read_busy, "R7", "burst still busy", read_busy, 1);
        for (int i = 0; i < 6; i++) pop_rx("R7");
        wait_quiet();
        chk(count_r(seq_log) == 6 && !read_busy, "R7", "burst resumes", count_r(seq_log), 6);

        // R8: count latched at request
        seq_log = "";
        ctl(1, 1, 1);
        ctl(1, 7, 1);
        wait_quiet();
        chk(count_r(seq_log) == 2, "R8", "latched burst length", count_r(seq_log), 2);
        for (int i = 0; i < 2; i++) pop_rx("R8");
        @(negedge clk);
        chk(rx_empty && !read_busy, "R8", "no second burst", rx_empty, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule